// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the ordered list of column addresses that the burst visits, one address per clock. A request carries a starting column, a length choice (four or eight beats) and an ordering choice (sequential or interleaved). Length and ordering apply in the same way to reads and to writes.

The burst never leaves the aligned block that contains the starting column. That block is four columns wide for a four-beat burst and eight columns wide for an eight-beat burst. Only the low offset bits move, and they wrap inside the block. For sequential eight-beat bursts the order works in nibbles. The two low bits count upward modulo four. Bit 2 flips once, after the first four beats. Interleaved order XORs the start offset with the beat number.

While a burst runs, the block shows a valid flag and flags its final beat. Requests that arrive during a burst are dropped. The controller issuing requests sees a one-cycle idle gap between bursts.

Top module: `burst_col_seq`

## Requirements
- R1: While reset (rst_n low) is held, valid_o and last_o are low.
- R2: A start_i pulse sampled while no burst is running makes valid_o high at the next clock, and col_o on that first beat equals the start_col_i that was sampled.
- R3: With bl8_i = 1 sampled at the start, valid_o stays high for exactly 8 consecutive cycles. With bl8_i = 0 it stays high for exactly 4.
- R4: During a burst, the column bits above bit 1 (four beats) or above bit 2 (eight beats) stay equal to those of the start column.
- R5: Four beats with intlv_i = 0: the offset on beat i (bits 1:0) is (start offset + i) mod 4.
- R6: Four beats with intlv_i = 1: the offset on beat i (bits 1:0) is start offset XOR i.
- R7: Eight beats with intlv_i = 0: on beat i, bits 1:0 are (start bits 1:0 + i) mod 4, and bit 2 is start bit 2 XOR (i >= 4).
- R8: Eight beats with intlv_i = 1: the offset on beat i (bits 2:0) is start offset XOR i.
- R9: last_o is high on the final beat of a burst and on no other cycle.
- R10: A start_i seen while a burst is running is ignored, including on the final beat. A new burst can only be accepted on the cycle after the final beat.
- R11: Changes on start_col_i, bl8_i and intlv_i during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request, sampled on each edge |
| start_col_i | input | COL_W | Starting column address of the request |
| bl8_i | input | 1 | Burst length select: 1 = eight beats, 0 = four beats |
| intlv_i | input | 1 | Ordering select: 1 = interleaved, 0 = sequential |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | High on every beat of a burst |
| last_o | output | 1 | High on the final beat of a burst |

## Verification
The bench builds the block with the default COL_W of 10. This leaves seven block-select bits above the largest offset field. Those bits can be random or all ones, so an increment that wrongly carried out of the aligned block would show up as a change in the upper column bits. Every start offset from 0 to 7 is run in all four length and ordering combinations. Later phases hold start_i high without a break and scramble the mode inputs on every cycle, which exercises the dropped-request and captured-mode rules.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        BLEN_4 = 1'b0,
        BLEN_8 = 1'b1
    } burst_len_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } burst_order_e;

    localparam int OFS_W  = 3;
    localparam int BEAT_W = 3;

    function automatic logic [BEAT_W-1:0] final_beat(burst_len_e len);
        return (len == BLEN_8) ? BEAT_W'(7) : BEAT_W'(3);
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [COL_W-1:0]    start_col_i,
    input  logic                bl8_i,
    input  logic                intlv_i,
    output logic                active_o,
    output logic                last_o,
    output logic [BEAT_W-1:0]   beat_o,
    output logic [COL_W-1:0]    base_o,
    output burst_len_e          len_o,
    output burst_order_e        order_o
);

    typedef struct packed {
        logic                active;
        logic [BEAT_W-1:0]   beat;
        logic [COL_W-1:0]    base;
        burst_len_e          len;
        burst_order_e        order;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  at_end;

    always_comb begin
        nxt_d  = cur_q;
        at_end = cur_q.active && (cur_q.beat == final_beat(cur_q.len));
        if (!cur_q.active) begin
            if (start_i) begin
                nxt_d.active = 1'b1;
                nxt_d.beat   = '0;
                nxt_d.base   = start_col_i;
                nxt_d.len    = bl8_i   ? BLEN_8    : BLEN_4;
                nxt_d.order  = intlv_i ? ORD_INTLV : ORD_SEQ;
            end
        end else if (at_end) begin
            nxt_d.active = 1'b0;
            nxt_d.beat   = '0;
        end else begin
            nxt_d.beat = cur_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{active: 1'b0, beat: '0, base: '0, len: BLEN_4, order: ORD_SEQ};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active_o = cur_q.active;
    assign last_o   = at_end;
    assign beat_o   = cur_q.beat;
    assign base_o   = cur_q.base;
    assign len_o    = cur_q.len;
    assign order_o  = cur_q.order;

endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
    import burst_seq_pkg::*;
(
    input  logic [OFS_W-1:0]  start_ofs_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_len_e        len_i,
    input  burst_order_e      order_i,
    output logic [OFS_W-1:0]  ofs_o
);

    logic [1:0] lo_count;
    logic       hi_flip;

    always_comb begin
        lo_count = start_ofs_i[1:0] + beat_i[1:0];
        hi_flip  = (len_i == BLEN_8) ? beat_i[2] : 1'b0;
        if (order_i == ORD_INTLV) begin
            ofs_o = {start_ofs_i[2] ^ hi_flip, start_ofs_i[1:0] ^ beat_i[1:0]};
        end else begin
            ofs_o = {start_ofs_i[2] ^ hi_flip, lo_count};
        end
    end

endmodule

// File: rtl/burst_addr_merge.sv
module burst_addr_merge
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  burst_len_e       len_i,
    output logic [COL_W-1:0] col_o
);

    always_comb begin
        col_o      = base_i;
        col_o[1:0] = ofs_i[1:0];
        if (len_i == BLEN_8) begin
            col_o[2] = ofs_i[2];
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             bl8_i,
    input  logic             intlv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    logic               active;
    logic               at_end;
    logic [BEAT_W-1:0]  beat;
    logic [COL_W-1:0]   base;
    burst_len_e         len;
    burst_order_e       order;
    logic [OFS_W-1:0]   ofs;

    burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl8_i       (bl8_i),
        .intlv_i     (intlv_i),
        .active_o    (active),
        .last_o      (at_end),
        .beat_o      (beat),
        .base_o      (base),
        .len_o       (len),
        .order_o     (order)
    );

    burst_offset_gen u_ofs (
        .start_ofs_i (base[OFS_W-1:0]),
        .beat_i      (beat),
        .len_i       (len),
        .order_i     (order),
        .ofs_o       (ofs)
    );

    burst_addr_merge #(.COL_W(COL_W)) u_merge (
        .base_i (base),
        .ofs_i  (ofs),
        .len_i  (len),
        .col_o  (col_o)
    );

    assign valid_o = active;
    assign last_o  = at_end;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             bl8_i,
    input logic             intlv_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    logic [2:0] seen_q;
    logic       cap8_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            cap8_q <= 1'b0;
        end else if (!valid_o && start_i) begin
            seen_q <= '0;
            cap8_q <= bl8_i;
        end else if (valid_o) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && col_o == $past(start_col_i)));

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (seen_q == (cap8_q ? 3'd7 : 3'd3)));

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    // R4
    block4_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !cap8_q) |=> (col_o[COL_W-1:2] == $past(col_o[COL_W-1:2])));

    // R9
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R10
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    // R10
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] scol = '0;
    logic             bl8 = 1'b0;
    logic             il = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    string phase = "R5";
    int    exp_q[$];
    int    tag_q[$];

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(scol),
        .bl8_i(bl8), .intlv_i(il), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic int exp_col(int s, int i, bit b8, bit iv);
        int off;
        if (b8) begin
            if (iv) off = (s & 7) ^ i;
            else    off = ((s & 4) ^ (i & 4)) | (((s & 3) + i) & 3);
            return (s & ~7) | off;
        end
        off = iv ? ((s & 3) ^ i) : ((s + i) & 3);
        return (s & ~3) | off;
    endfunction

    function automatic string tag_name(int code);
        case (code)
            2: return "R2";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (phase %s): actual=%0h expected=%0h", tag, phase, act, exp);
        end
    endtask

    // Reference model: accepts a request only when its queue is empty before the edge (R10, R11)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            tag_q.delete();
        end else begin
            bit busy;
            busy = exp_q.size() > 0;
            if (busy) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (!busy && start) begin
                for (int i = 0; i < (bl8 ? 8 : 4); i++) begin
                    exp_q.push_back(exp_col(int'(scol), i, bl8, il));
                    tag_q.push_back(i == 0 ? 2 : (bl8 ? (il ? 8 : 7) : (il ? 6 : 5)));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev;
            ev = exp_q.size() > 0;
            check(valid_o == ev, "R3", int'(valid_o), int'(ev));
            if (ev) begin
                check(last_o == (exp_q.size() == 1), "R9", int'(last_o), int'(exp_q.size() == 1));
                check(int'(col_o) == exp_q[0], tag_name(tag_q[0]), int'(col_o), exp_q[0]);
                check(int'(col_o[COL_W-1:3]) == (exp_q[0] >> 3), "R4",
                      int'(col_o[COL_W-1:3]), exp_q[0] >> 3);
            end else begin
                check(last_o == 1'b0, "R9", int'(last_o), 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", int'(valid_o), 0);
        check(last_o == 1'b0, "R1", int'(last_o), 0);
        rst_n = 1'b1;

        // R5 R6 R7 R8: every offset in every length/order combination
        for (int b = 0; b < 2; b++) begin
            for (int v = 0; v < 2; v++) begin
                phase = b ? (v ? "R8" : "R7") : (v ? "R6" : "R5");
                for (int s = 0; s < 8; s++) begin
                    @(negedge clk);
                    scol  = {((s % 2) != 0) ? 7'h7F : 7'($urandom), 3'(s)};
                    bl8   = b[0];
                    il    = v[0];
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    repeat (9) @(negedge clk);
                end
            end
        end

        // R10: request held high, so requests overlap every burst and its final beat
        phase = "R10";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            start = 1'b1;
            scol  = COL_W'($urandom);
            bl8   = 1'($urandom);
            il    = 1'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        // R11: mode and column inputs scrambled while bursts run
        phase = "R11";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            start = (k % 11) == 0;
            scol  = COL_W'($urandom);
            bl8   = 1'($urandom);
            il    = 1'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule